// File: doc/BRIEF.md
# Nested Trap Level Stack

This block tracks how deeply a processor is nested in trap handlers and keeps one saved context per level. When a trap is taken, the live program counter, next program counter and trap type are stored in the slot of the current level. The live condition codes, address-space identifier, processor state and current window are stored there too, packed into one state word. The block then forms the handler address from the trap base and the trap type, moves to the next level, and reports the redirect target together with the processor state the handler runs under.

There are two ways to leave a handler, and both pop one level. The first resumes after the trapping instruction: the saved next PC becomes the PC. The second re-executes the trapping instruction: the saved PC and next PC come back unchanged. In both cases the condition codes, address-space identifier, processor state and window are restored from the slot of the level returned to. As nesting approaches its limit, the block marks a reduced-state condition in the processor state. A trap taken at the limit is reported as an error and changes nothing.

All results are registered. A request sampled on a clock edge produces its redirect, its level change and its error pulse in the cycle after that edge. The live values must be stable during the request cycle.

Top module: `trap_level_stack`

## Requirements
- R1: After reset, `trap_lvl` is 0, `redirect` and `trap_err` are 0, and `lvl_tt` and `lvl_tstate` read 0.
- R2: A trap taken with the level below MAXTL-1 raises the level by one. It pulses `redirect` for one cycle, sets `new_pstate` to 0x015 (bit 4 FP enable, bit 2 privileged, bit 0 alternate globals), and passes the live condition codes, ASI and window through to `new_ccr`, `new_asi` and `new_cwp`.
- R3: On any accepted trap, `new_pc` equals the trap base with bits [14:0] cleared, with bit 14 set if the level before the trap was greater than 1, and with the trap type placed at bits [13:5]. `new_npc` equals `new_pc` + 4.
- R4: A trap taken at level MAXTL-1 behaves as in R2 but also sets the reduced-state bit 5, so `new_pstate` is 0x035, and the level becomes MAXTL.
- R5: A trap taken at level MAXTL pulses `trap_err` for one cycle without `redirect`. The level stays the same and no slot is written, so `lvl_tt`, `lvl_tstate` and later restores still reflect the earlier contents.
- R6: A resume-after request at a nonzero level lowers the level by one. It sets `new_pc` to the saved next PC of the slot returned to, and `new_npc` to that value + 4.
- R7: A re-execute request at a nonzero level lowers the level by one. It sets `new_pc` and `new_npc` to the saved PC and next PC of the slot returned to.
- R8: When requests coincide, a trap wins over both pop requests, and resume-after wins over re-execute.
- R9: A pop request at level 0 is ignored: there is no `redirect`, no `trap_err` and no level change.
- R10: On every pop, `new_ccr`, `new_asi`, `new_pstate` and `new_cwp` are restored from the state word of the slot returned to. `lvl_tstate` shows the state word of slot level-1: condition codes at bits 32 and up, ASI at [31:24], zero at [23:20], processor state at [19:8], window at [7:0]. It reads 0 at level 0.
- R11: `lvl_tt` shows the trap type saved in slot level-1, or 0 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | TT_W | Trap type of the trap being taken |
| done_req | input | 1 | Pop and resume after the trapping instruction |
| retry_req | input | 1 | Pop and re-execute the trapping instruction |
| tba | input | AW | Trap base address |
| cur_pc | input | AW | Live program counter |
| cur_npc | input | AW | Live next program counter |
| cur_ccr | input | CCR_W | Live condition codes |
| cur_asi | input | 8 | Live address-space identifier |
| cur_pstate | input | 12 | Live processor state |
| cur_cwp | input | 8 | Live current window |
| redirect | output | 1 | One-cycle pulse: the new_* outputs are a fresh target |
| new_pc | output | AW | Redirect program counter |
| new_npc | output | AW | Redirect next program counter |
| new_ccr | output | CCR_W | Condition codes to install |
| new_asi | output | 8 | ASI to install |
| new_pstate | output | 12 | Processor state to install |
| new_cwp | output | 8 | Window to install |
| trap_lvl | output | TLW | Current trap level, 0 to MAXTL |
| trap_err | output | 1 | One-cycle pulse: trap taken at the maximum level |
| lvl_tt | output | TT_W | Trap type saved for the current level |
| lvl_tstate | output | CCR_W+32 | State word saved for the current level |

## Verification
Some properties are checked by the assertions on every cycle. The level never exceeds MAXTL and moves by exactly one on each accepted push or pop. A trap at the limit yields an error with no redirect and a frozen level. Every trap target is 32-byte aligned, has its level bit set exactly when the prior level exceeded 1, and has a next PC four beyond it. A pop at level 0 does nothing, and the reduced-state bit appears on the last legal push. Other behaviour only the bench scenarios can show, because it needs values written many cycles earlier. This covers whether a pop returns the right slot's PC, next PC, state word and trap type; whether an error trap left every slot untouched; and how coinciding requests are resolved.

// File: rtl/tls_pkg.sv
`timescale 1ns/1ps
package tls_pkg;

  // effective operation chosen for a cycle
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_TRAP  = 2'd1,
    OP_DONE  = 2'd2,
    OP_RETRY = 2'd3
  } tls_op_e;

  // handler address formation
  localparam int VEC_CLR_BITS = 15;  // low bits of the base that are cleared
  localparam int VEC_LVL_BIT  = 14;  // set when trapping from level > 1
  localparam int VEC_TT_LSB   = 5;   // trap type position

  // processor state bits installed on entry
  localparam int PST_W        = 12;
  localparam int PST_AG_BIT   = 0;
  localparam int PST_PRIV_BIT = 2;
  localparam int PST_PEF_BIT  = 4;
  localparam int PST_RED_BIT  = 5;

  // state word field positions
  localparam int SW_CWP_LSB = 0;
  localparam int SW_PST_LSB = 8;
  localparam int SW_ASI_LSB = 24;
  localparam int SW_CCR_LSB = 32;
  localparam int ASI_W      = 8;
  localparam int CWP_W      = 8;

endpackage

// File: rtl/tls_ctrl.sv
`timescale 1ns/1ps
module tls_ctrl
  import tls_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TLW   = $clog2(MAXTL + 1)
) (
  input  logic           trap_req,
  input  logic           done_req,
  input  logic           retry_req,
  input  logic [TLW-1:0] lvl_q,
  output tls_op_e        act_op,
  output logic           save_en,
  output logic           red_set,
  output logic           err_d,
  output logic [TLW-1:0] lvl_d
);

  localparam logic [TLW-1:0] LVL_MAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] LVL_LAST = TLW'(MAXTL - 1);

  logic at_max;
  logic at_zero;

  assign at_max  = (lvl_q == LVL_MAX);
  assign at_zero = (lvl_q == '0);

  always_comb begin
    act_op  = OP_NONE;
    save_en = 1'b0;
    red_set = 1'b0;
    err_d   = 1'b0;
    lvl_d   = lvl_q;
    if (trap_req) begin
      if (at_max) begin
        err_d = 1'b1;
      end else begin
        act_op  = OP_TRAP;
        save_en = 1'b1;
        red_set = (lvl_q == LVL_LAST);
        lvl_d   = lvl_q + TLW'(1);
      end
    end else if (done_req || retry_req) begin
      if (!at_zero) begin
        act_op = done_req ? OP_DONE : OP_RETRY;
        lvl_d  = lvl_q - TLW'(1);
      end
    end
  end

endmodule

// File: rtl/tls_vector.sv
`timescale 1ns/1ps
module tls_vector
  import tls_pkg::*;
#(
  parameter int AW   = 64,
  parameter int TT_W = 9,
  parameter int TLW  = 3
) (
  input  logic [AW-1:0]   tba,
  input  logic [TT_W-1:0] tt,
  input  logic [TLW-1:0]  lvl_q,
  output logic [AW-1:0]   vec
);

  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << VEC_CLR_BITS) - AW'(1);

  logic nested;

  assign nested = (lvl_q > TLW'(1));

  always_comb begin
    vec = (tba & ~LOW_MASK)
        | (AW'(nested) << VEC_LVL_BIT)
        | (AW'(tt) << VEC_TT_LSB);
  end

endmodule

// File: rtl/tls_store.sv
`timescale 1ns/1ps
module tls_store #(
  parameter int DEPTH = 5,
  parameter int IW    = 3,
  parameter int SW    = 40,
  parameter int AW    = 64,
  parameter int TT_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [SW-1:0]   wr_state,
  input  logic [AW-1:0]   wr_pc,
  input  logic [AW-1:0]   wr_npc,
  input  logic [TT_W-1:0] wr_tt,
  input  logic [IW-1:0]   rd_idx,
  output logic [SW-1:0]   rd_state,
  output logic [AW-1:0]   rd_pc,
  output logic [AW-1:0]   rd_npc,
  output logic [TT_W-1:0] rd_tt
);

  logic [SW-1:0]   st_all  [DEPTH];
  logic [AW-1:0]   pc_all  [DEPTH];
  logic [AW-1:0]   npc_all [DEPTH];
  logic [TT_W-1:0] tt_all  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic            hit;
    logic [SW-1:0]   st_q,  st_d;
    logic [AW-1:0]   pc_q,  pc_d;
    logic [AW-1:0]   npc_q, npc_d;
    logic [TT_W-1:0] tt_q,  tt_d;

    assign hit = wr_en && (wr_idx == IW'(g));

    always_comb begin
      st_d  = st_q;
      pc_d  = pc_q;
      npc_d = npc_q;
      tt_d  = tt_q;
      if (hit) begin
        st_d  = wr_state;
        pc_d  = wr_pc;
        npc_d = wr_npc;
        tt_d  = wr_tt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= '0;
        pc_q  <= '0;
        npc_q <= '0;
        tt_q  <= '0;
      end else begin
        st_q  <= st_d;
        pc_q  <= pc_d;
        npc_q <= npc_d;
        tt_q  <= tt_d;
      end
    end

    assign st_all[g]  = st_q;
    assign pc_all[g]  = pc_q;
    assign npc_all[g] = npc_q;
    assign tt_all[g]  = tt_q;
  end

  always_comb begin
    rd_state = '0;
    rd_pc    = '0;
    rd_npc   = '0;
    rd_tt    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_state = st_all[i];
        rd_pc    = pc_all[i];
        rd_npc   = npc_all[i];
        rd_tt    = tt_all[i];
      end
    end
  end

endmodule

// File: rtl/trap_level_stack.sv
`timescale 1ns/1ps
module trap_level_stack
  import tls_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int AW    = 64,
  parameter int TT_W  = 9,
  parameter int CCR_W = 8,
  parameter int TLW   = $clog2(MAXTL + 1),
  parameter int SW    = CCR_W + SW_CCR_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [TT_W-1:0]  trap_type,
  input  logic             done_req,
  input  logic             retry_req,
  input  logic [AW-1:0]    tba,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    cur_npc,
  input  logic [CCR_W-1:0] cur_ccr,
  input  logic [7:0]       cur_asi,
  input  logic [11:0]      cur_pstate,
  input  logic [7:0]       cur_cwp,
  output logic             redirect,
  output logic [AW-1:0]    new_pc,
  output logic [AW-1:0]    new_npc,
  output logic [CCR_W-1:0] new_ccr,
  output logic [7:0]       new_asi,
  output logic [11:0]      new_pstate,
  output logic [7:0]       new_cwp,
  output logic [TLW-1:0]   trap_lvl,
  output logic             trap_err,
  output logic [TT_W-1:0]  lvl_tt,
  output logic [SW-1:0]    lvl_tstate
);

  localparam int IW = (MAXTL > 1) ? $clog2(MAXTL) : 1;
  localparam logic [AW-1:0] INSN_STEP = AW'(4);
  localparam logic [PST_W-1:0] PST_ENTRY =
      PST_W'((1 << PST_PEF_BIT) | (1 << PST_PRIV_BIT) | (1 << PST_AG_BIT));
  localparam logic [PST_W-1:0] PST_RED = PST_W'(1 << PST_RED_BIT);
  localparam int GAP_W = SW_PST_LSB + PST_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // control
  tls_op_e        act_op;
  logic           save_en, red_set, err_d;
  logic [TLW-1:0] lvl_q, lvl_d;

  tls_ctrl #(.MAXTL(MAXTL), .TLW(TLW)) u_ctrl (
    .trap_req (trap_req),
    .done_req (done_req),
    .retry_req(retry_req),
    .lvl_q    (lvl_q),
    .act_op   (act_op),
    .save_en  (save_en),
    .red_set  (red_set),
    .err_d    (err_d),
    .lvl_d    (lvl_d)
  );

  // handler address
  logic [AW-1:0] vec;

  tls_vector #(.AW(AW), .TT_W(TT_W), .TLW(TLW)) u_vec (
    .tba  (tba),
    .tt   (trap_type),
    .lvl_q(lvl_q),
    .vec  (vec)
  );

  // per-level storage
  logic [SW-1:0]   wr_state;
  logic [IW-1:0]   wr_idx, rd_idx;
  logic [SW-1:0]   rd_state;
  logic [AW-1:0]   rd_pc, rd_npc;
  logic [TT_W-1:0] rd_tt;
  logic            lvl_nz;

  assign wr_state = {cur_ccr, cur_asi,
                     {(SW_ASI_LSB - GAP_W){1'b0}},
                     cur_pstate, cur_cwp};
  assign lvl_nz   = (lvl_q != '0);
  assign wr_idx   = IW'(lvl_q);
  assign rd_idx   = lvl_nz ? IW'(lvl_q - TLW'(1)) : '0;

  tls_store #(
    .DEPTH(MAXTL), .IW(IW), .SW(SW), .AW(AW), .TT_W(TT_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (save_en),
    .wr_idx  (wr_idx),
    .wr_state(wr_state),
    .wr_pc   (cur_pc),
    .wr_npc  (cur_npc),
    .wr_tt   (trap_type),
    .rd_idx  (rd_idx),
    .rd_state(rd_state),
    .rd_pc   (rd_pc),
    .rd_npc  (rd_npc),
    .rd_tt   (rd_tt)
  );

  // unpack the slot being returned to
  logic [CCR_W-1:0] rs_ccr;
  logic [7:0]       rs_asi;
  logic [11:0]      rs_pst;
  logic [7:0]       rs_cwp;

  assign rs_ccr = rd_state[SW_CCR_LSB +: CCR_W];
  assign rs_asi = rd_state[SW_ASI_LSB +: ASI_W];
  assign rs_pst = rd_state[SW_PST_LSB +: PST_W];
  assign rs_cwp = rd_state[SW_CWP_LSB +: CWP_W];

  // output next state
  logic             redir_d, out_en;
  logic [AW-1:0]    pc_d, npc_d;
  logic [CCR_W-1:0] ccr_d;
  logic [7:0]       asi_d, cwp_d;
  logic [11:0]      pst_d;

  logic             redir_q, err_q;
  logic [AW-1:0]    pc_q, npc_q;
  logic [CCR_W-1:0] ccr_q;
  logic [7:0]       asi_q, cwp_q;
  logic [11:0]      pst_q;

  assign redir_d = (act_op != OP_NONE);
  assign out_en  = redir_d;

  always_comb begin
    pc_d  = pc_q;
    npc_d = npc_q;
    ccr_d = ccr_q;
    asi_d = asi_q;
    pst_d = pst_q;
    cwp_d = cwp_q;
    unique case (act_op)
      OP_TRAP: begin
        pc_d  = vec;
        npc_d = vec + INSN_STEP;
        ccr_d = cur_ccr;
        asi_d = cur_asi;
        pst_d = PST_ENTRY | (red_set ? PST_RED : '0);
        cwp_d = cur_cwp;
      end
      OP_DONE: begin
        pc_d  = rd_npc;
        npc_d = rd_npc + INSN_STEP;
        ccr_d = rs_ccr;
        asi_d = rs_asi;
        pst_d = rs_pst;
        cwp_d = rs_cwp;
      end
      OP_RETRY: begin
        pc_d  = rd_pc;
        npc_d = rd_npc;
        ccr_d = rs_ccr;
        asi_d = rs_asi;
        pst_d = rs_pst;
        cwp_d = rs_cwp;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_q   <= '0;
      redir_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      redir_q <= redir_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      npc_q <= '0;
      ccr_q <= '0;
      asi_q <= '0;
      pst_q <= '0;
      cwp_q <= '0;
    end else if (out_en) begin
      pc_q  <= pc_d;
      npc_q <= npc_d;
      ccr_q <= ccr_d;
      asi_q <= asi_d;
      pst_q <= pst_d;
      cwp_q <= cwp_d;
    end
  end

  assign redirect   = redir_q;
  assign trap_err   = err_q;
  assign trap_lvl   = lvl_q;
  assign new_pc     = pc_q;
  assign new_npc    = npc_q;
  assign new_ccr    = ccr_q;
  assign new_asi    = asi_q;
  assign new_pstate = pst_q;
  assign new_cwp    = cwp_q;
  assign lvl_tt     = lvl_nz ? rd_tt : '0;
  assign lvl_tstate = lvl_nz ? rd_state : '0;

endmodule

// File: rtl/tls_checker.sv
`timescale 1ns/1ps
module tls_checker #(
  parameter int MAXTL = 5,
  parameter int AW    = 64,
  parameter int TLW   = 3
) (
  input logic           clk,
  input logic           rst_ok_n,
  input logic           trap_req,
  input logic           done_req,
  input logic           retry_req,
  input logic           redirect,
  input logic           trap_err,
  input logic [AW-1:0]  new_pc,
  input logic [AW-1:0]  new_npc,
  input logic [11:0]    new_pstate,
  input logic [TLW-1:0] trap_lvl
);

  localparam logic [TLW-1:0] LMAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] LLAST = TLW'(MAXTL - 1);

  // R2: the level is bounded by the maximum
  assert_lvl_bound_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    trap_lvl <= LMAX);

  // R2: accepted trap pushes one level and redirects
  assert_push_one_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_req && trap_lvl != LMAX) |=>
      (redirect && trap_lvl == $past(trap_lvl) + TLW'(1)));

  // R3: handler target alignment, level bit and next PC
  assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_req && trap_lvl != LMAX) |=>
      (new_pc[4:0] == 5'd0 && new_npc == new_pc + AW'(4) &&
       new_pc[14] == ($past(trap_lvl) > TLW'(1))));

  // R4: last legal push enters reduced state
  assert_red_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_req && trap_lvl == LLAST) |=> (new_pstate[5] && trap_lvl == LMAX));

  // R5: trap at the limit is an error and freezes the level
  assert_full_err_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_req && trap_lvl == LMAX) |=>
      (trap_err && !redirect && $stable(trap_lvl)));

  // R6: a pop at nonzero level lowers the level by one
  assert_pop_one_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!trap_req && (done_req || retry_req) && trap_lvl != '0) |=>
      (redirect && trap_lvl == $past(trap_lvl) - TLW'(1)));

  // R9: a pop at level zero does nothing
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!trap_req && (done_req || retry_req) && trap_lvl == '0) |=>
      (!redirect && !trap_err && trap_lvl == '0));

  // R5: error and redirect never coincide
  assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(redirect && trap_err));

endmodule

bind trap_level_stack tls_checker #(
  .MAXTL(MAXTL), .AW(AW), .TLW(TLW)
) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .trap_req  (trap_req),
  .done_req  (done_req),
  .retry_req (retry_req),
  .redirect  (redirect),
  .trap_err  (trap_err),
  .new_pc    (new_pc),
  .new_npc   (new_npc),
  .new_pstate(new_pstate),
  .trap_lvl  (trap_lvl)
);

// File: tb/sim_trap_level_stack.sv
`timescale 1ns/1ps
module sim_trap_level_stack;

  localparam int MAXTL = 5;
  localparam int AW    = 64;
  localparam int TT_W  = 9;
  localparam int CCR_W = 8;
  localparam int TLW   = $clog2(MAXTL + 1);
  localparam int SW    = CCR_W + 32;
  localparam logic [AW-1:0] TBA = 64'hFFFF_0000_0012_3456;

  // op codes: 0 trap, 1 done, 2 retry, 3 trap+done, 4 done+retry
  localparam int NV = 20;
  localparam logic [19:0] TBL [NV] = '{
    {3'd0, 9'h041, 8'h11},
    {3'd0, 9'h009, 8'h22},
    {3'd0, 9'h1FF, 8'h33},
    {3'd0, 9'h100, 8'h44},
    {3'd0, 9'h080, 8'h55},
    {3'd0, 9'h007, 8'h66},
    {3'd2, 9'h000, 8'h00},
    {3'd1, 9'h000, 8'h00},
    {3'd0, 9'h022, 8'h77},
    {3'd4, 9'h000, 8'h00},
    {3'd3, 9'h033, 8'h88},
    {3'd1, 9'h000, 8'h00},
    {3'd1, 9'h000, 8'h00},
    {3'd2, 9'h000, 8'h00},
    {3'd1, 9'h000, 8'h00},
    {3'd1, 9'h000, 8'h00},
    {3'd2, 9'h000, 8'h00},
    {3'd0, 9'h001, 8'h99},
    {3'd2, 9'h000, 8'h00},
    {3'd0, 9'h0AB, 8'hAA}
  };

  logic             clk, rst_n;
  logic             trap_req, done_req, retry_req;
  logic [TT_W-1:0]  trap_type;
  logic [AW-1:0]    tba, cur_pc, cur_npc;
  logic [CCR_W-1:0] cur_ccr;
  logic [7:0]       cur_asi, cur_cwp;
  logic [11:0]      cur_pstate;
  logic             redirect, trap_err;
  logic [AW-1:0]    new_pc, new_npc;
  logic [CCR_W-1:0] new_ccr;
  logic [7:0]       new_asi, new_cwp;
  logic [11:0]      new_pstate;
  logic [TLW-1:0]   trap_lvl;
  logic [TT_W-1:0]  lvl_tt;
  logic [SW-1:0]    lvl_tstate;

  trap_level_stack #(.MAXTL(MAXTL), .AW(AW), .TT_W(TT_W), .CCR_W(CCR_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .trap_req(trap_req), .trap_type(trap_type),
    .done_req(done_req), .retry_req(retry_req), .tba(tba),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr),
    .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
    .redirect(redirect), .new_pc(new_pc), .new_npc(new_npc),
    .new_ccr(new_ccr), .new_asi(new_asi), .new_pstate(new_pstate),
    .new_cwp(new_cwp), .trap_lvl(trap_lvl), .trap_err(trap_err),
    .lvl_tt(lvl_tt), .lvl_tstate(lvl_tstate)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model
  logic [AW-1:0]   m_pc  [MAXTL];
  logic [AW-1:0]   m_npc [MAXTL];
  logic [TT_W-1:0] m_tt  [MAXTL];
  logic [SW-1:0]   m_st  [MAXTL];
  int              m_tl;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_level(input string req);
    chk(req, "trap_lvl", 64'(trap_lvl), 64'(m_tl));
    chk("R11", "lvl_tt", 64'(lvl_tt), (m_tl > 0) ? 64'(m_tt[m_tl-1]) : 64'd0);
    chk("R10", "lvl_tstate", 64'(lvl_tstate),
        (m_tl > 0) ? 64'(m_st[m_tl-1]) : 64'd0);
  endtask

  task automatic step(input int op, input logic [TT_W-1:0] tt, input logic [7:0] sd);
    logic do_trap, do_done, do_retry, e_redir, e_err;
    logic [AW-1:0] e_pc, e_npc;
    logic [SW-1:0] st;
    logic [11:0] e_pst;
    string tag;
    do_trap  = (op == 0) || (op == 3);
    do_done  = (op == 1) || (op == 3) || (op == 4);
    do_retry = (op == 2) || (op == 4);
    trap_req   = do_trap;
    done_req   = do_done;
    retry_req  = do_retry;
    trap_type  = tt;
    cur_pc     = 64'h0000_0000_4000_0000 + {48'd0, sd, 8'h00};
    cur_npc    = cur_pc + 64'h24;
    cur_ccr    = sd ^ 8'h5A;
    cur_asi    = ~sd;
    cur_pstate = {sd[3:0], sd};
    cur_cwp    = sd;
    e_redir = 1'b0; e_err = 1'b0;
    e_pc = '0; e_npc = '0; e_pst = '0; st = '0;
    tag = (op >= 3) ? "R8" : "R2";
    if (do_trap) begin
      if (m_tl == MAXTL) begin
        e_err = 1'b1;
        tag = "R5";
      end else begin
        e_redir = 1'b1;
        e_pc = (TBA & ~64'h7FFF) | ((m_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
        e_npc = e_pc + 64'd4;
        e_pst = 12'h015 | ((m_tl == MAXTL - 1) ? 12'h020 : 12'h000);
        if (m_tl == MAXTL - 1) tag = "R4";
        m_pc[m_tl]  = cur_pc;
        m_npc[m_tl] = cur_npc;
        m_tt[m_tl]  = tt;
        m_st[m_tl]  = {cur_ccr, cur_asi, 4'h0, cur_pstate, cur_cwp};
        m_tl++;
      end
    end else if (m_tl == 0) begin
      tag = "R9";
    end else begin
      m_tl--;
      e_redir = 1'b1;
      st = m_st[m_tl];
      e_pst = st[19:8];
      if (do_done) begin
        e_pc  = m_npc[m_tl];
        e_npc = m_npc[m_tl] + 64'd4;
        if (op < 3) tag = "R6";
      end else begin
        e_pc  = m_pc[m_tl];
        e_npc = m_npc[m_tl];
        tag = "R7";
      end
    end
    @(negedge clk);
    trap_req = 1'b0; done_req = 1'b0; retry_req = 1'b0;
    chk(tag, "redirect", 64'(redirect), 64'(e_redir));
    chk(tag, "trap_err", 64'(trap_err), 64'(e_err));
    check_level(tag);
    if (e_redir) begin
      chk(tag, "new_pc", new_pc, e_pc);
      chk(tag, "new_npc", new_npc, e_npc);
      chk(do_trap ? tag : "R10", "new_pstate", 64'(new_pstate), 64'(e_pst));
      if (do_trap) begin
        chk("R2", "new_ccr", 64'(new_ccr), 64'(cur_ccr));
        chk("R2", "new_asi", 64'(new_asi), 64'(cur_asi));
        chk("R2", "new_cwp", 64'(new_cwp), 64'(cur_cwp));
      end else begin
        chk("R10", "new_ccr", 64'(new_ccr), 64'(st[39:32]));
        chk("R10", "new_asi", 64'(new_asi), 64'(st[31:24]));
        chk("R10", "new_cwp", 64'(new_cwp), 64'(st[7:0]));
      end
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    trap_req = 1'b0; done_req = 1'b0; retry_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_tl = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    tba = TBA;
    trap_type = '0; cur_pc = '0; cur_npc = '0; cur_ccr = '0;
    cur_asi = '0; cur_pstate = '0; cur_cwp = '0;
    apply_reset();
    // R1: reset state
    chk("R1", "redirect", 64'(redirect), 64'd0);
    chk("R1", "trap_err", 64'(trap_err), 64'd0);
    check_level("R1");

    for (int i = 0; i < NV; i++) begin
      step(int'(TBL[i][19:17]), TBL[i][16:8], TBL[i][7:0]);
    end

    // R1: reset in the middle of nesting returns to level 0
    step(0, 9'h0F0, 8'hBB);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "trap_lvl async", 64'(trap_lvl), 64'd0);
    chk("R1", "redirect async", 64'(redirect), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_tl = 0;
    check_level("R1");

    // R9: pops at level 0 after reset, then a clean push/pop (R2, R6)
    step(1, 9'h000, 8'h00);
    step(4, 9'h000, 8'h00);
    step(0, 9'h155, 8'hCC);
    step(1, 9'h000, 8'h00);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule